// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block paces an oversampling analog-to-digital converter. A processor runs on a fast clock and reaches the block through a small register port. It selects free-running or on-request operation, asks for single conversions, programs how long a conversion lasts, and can restore every setting with one command. The sequencer itself runs on the slower sampling clock. It counts accepted modulator samples until the programmed conversion length is reached. It then latches the converter output and emits a one-cycle trigger in the sampling domain. The processor side receives the new value together with a sticky interrupt.

The modulator and the decimation filter are outside the block. A sample-valid strobe and a data bus on the sampling side stand in for them. The value on the data bus at the final accepted sample becomes the result. Gain, offset, speed and bias settings for the analog front end are only stored here.

The sequencer has two states, SEQ_IDLE and SEQ_CONV. The transitions are:
- kick: SEQ_IDLE to SEQ_CONV, on a start pulse, a defaults pulse, or the continuous bit being set.
- restart: SEQ_CONV to SEQ_CONV, with the counters cleared, on a defaults pulse.
- rollover: SEQ_CONV to SEQ_CONV, at the last sample while the continuous bit is set.
- finish: SEQ_CONV to SEQ_IDLE, at the last sample while the continuous bit is clear.

Commands reach the sampling domain through toggle synchronizers. The busy level and the completion event come back the same way toward the processor.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word at address 0 reads 0x0220, with the element count field [7:4]=2, the ratio exponent [9:8]=2, and continuous [0], busy [3] and interrupt [15] all 0. The result at address 1 reads 0, and no conversion starts by itself.
- R2: A conversion lasts N x (8 << E) accepted samples. N is the element count field, and a value of 0 counts as 1. E is the ratio exponent field. A sample counts only in a sampling cycle where smp_valid is 1.
- R3: At the last sample the value on smp_data is stored as the result. conv_trig is high for exactly one sampling cycle, and address 1 returns that value.
- R4: While control bit 0 (continuous) is 1, each conversion is followed at once by the next one, without any further register write.
- R5: Writing 1 to control bit 1 (start) while idle and not continuous runs exactly one conversion. A start written while a conversion runs is ignored and does not lengthen the conversion.
- R6: Writing 1 to control bit 2 (defaults) does three things. It sets the element count to 2 and the exponent to 2, and clears the analog settings word. It abandons any running conversion and starts a fresh one of 64 samples. The count and exponent bits of that write are not used.
- R7: Clearing the continuous bit lets the running conversion complete, and then the sequencer stops.
- R8: Control bit 3 (busy) reads 0 when idle and 1 while a conversion runs. It rises a few sampling cycles after the starting write.
- R9: The interrupt (the irq port and control bit 15) is set when a result arrives on the processor side. It stays set until address 1 is read, and that read clears it.
- R10: The analog settings word at address 2 is a 16-bit read/write store with reset value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor-side clock |
| cpu_rst_n | input | 1 | Active-low reset, processor side |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 1 clears the interrupt) |
| reg_addr | input | 2 | Register address: 0 control, 1 result, 2 analog settings |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| irq | output | 1 | Sticky conversion-complete interrupt |
| smp_clk | input | 1 | Sampling clock |
| smp_rst_n | input | 1 | Active-low reset, sampling side |
| smp_valid | input | 1 | Modulator sample accepted this cycle |
| smp_data | input | 16 | Filter output, captured at the last sample |
| conv_trig | output | 1 | One-cycle end-of-conversion pulse, sampling domain |

## Verification
The bench uses the default parameters: two synchronizer stages, a base ratio of 8 samples, and default settings of 2 elements at exponent 2. These values keep conversions between 16 and 960 samples long. Exact spacing between triggers can therefore be measured over several lengths, including an element count of 0, and with the sample strobe held high or pulsing every other cycle. The same settings allow two timing checks. A start can be dropped into the middle of a 256-sample conversion, and a defaults command can cut a 960-sample one down to 64 samples. Both can be measured against a window a few sampling cycles wide.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int REG_W     = 16;
    localparam int ADDR_W    = 2;
    localparam int NCV_W     = 4;
    localparam int OSR_EXP_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_RESULT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_ANALOG = 2'd2;

    localparam int CB_CONT    = 0;
    localparam int CB_START   = 1;
    localparam int CB_DEF     = 2;
    localparam int CB_BUSY    = 3;
    localparam int CB_NCV_LSB = 4;
    localparam int CB_OSR_LSB = 8;
    localparam int CB_IRQ     = 15;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_CONV = 1'b1
    } seq_state_e;

endpackage

// File: rtl/adc_seq_bit_sync.sv
module adc_seq_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= {sr_q[STAGES-2:0], d};
        end
    end

    assign q = sr_q[STAGES-1];

endmodule

// File: rtl/adc_seq_tgl_sync.sv
module adc_seq_tgl_sync #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);

    logic            src_tgl_q;
    logic [STAGES:0] dst_sr_q;

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) begin
            src_tgl_q <= 1'b0;
        end else if (src_pulse) begin
            src_tgl_q <= ~src_tgl_q;
        end
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            dst_sr_q <= '0;
        end else begin
            dst_sr_q <= {dst_sr_q[STAGES-1:0], src_tgl_q};
        end
    end

    assign dst_pulse = dst_sr_q[STAGES] ^ dst_sr_q[STAGES-1];

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int DEF_NCV     = 2,
    parameter int DEF_OSR_EXP = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic                 busy_sync,
    input  logic                 done_pulse,
    input  logic [REG_W-1:0]     result_in,
    output logic                 cont,
    output logic                 start_pulse,
    output logic                 def_pulse,
    output logic [NCV_W-1:0]     ncv,
    output logic [OSR_EXP_W-1:0] osr_exp,
    output logic                 irq
);

    localparam logic [NCV_W-1:0]     NCV_RST = NCV_W'(DEF_NCV);
    localparam logic [OSR_EXP_W-1:0] EXP_RST = OSR_EXP_W'(DEF_OSR_EXP);

    logic                 cont_q;
    logic                 start_q;
    logic                 def_q;
    logic [NCV_W-1:0]     ncv_q;
    logic [OSR_EXP_W-1:0] exp_q;
    logic [REG_W-1:0]     analog_q;
    logic [REG_W-1:0]     result_q;
    logic                 irq_q;

    logic ctrl_wr;
    logic analog_wr;
    logic result_rd;

    assign ctrl_wr   = reg_wr && (reg_addr == ADDR_CTRL);
    assign analog_wr = reg_wr && (reg_addr == ADDR_ANALOG);
    assign result_rd = reg_rd && (reg_addr == ADDR_RESULT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cont_q   <= 1'b0;
            start_q  <= 1'b0;
            def_q    <= 1'b0;
            ncv_q    <= NCV_RST;
            exp_q    <= EXP_RST;
            analog_q <= '0;
        end else begin
            start_q <= ctrl_wr && reg_wdata[CB_START];
            def_q   <= ctrl_wr && reg_wdata[CB_DEF];
            if (ctrl_wr) begin
                cont_q <= reg_wdata[CB_CONT];
                if (reg_wdata[CB_DEF]) begin
                    ncv_q <= NCV_RST;
                    exp_q <= EXP_RST;
                end else begin
                    ncv_q <= reg_wdata[CB_NCV_LSB +: NCV_W];
                    exp_q <= reg_wdata[CB_OSR_LSB +: OSR_EXP_W];
                end
            end
            if (ctrl_wr && reg_wdata[CB_DEF]) begin
                analog_q <= '0;
            end else if (analog_wr) begin
                analog_q <= reg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            if (done_pulse) begin
                result_q <= result_in;
                irq_q    <= 1'b1;
            end else if (result_rd) begin
                irq_q    <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CB_CONT]                    = cont_q;
                reg_rdata[CB_BUSY]                    = busy_sync;
                reg_rdata[CB_NCV_LSB +: NCV_W]        = ncv_q;
                reg_rdata[CB_OSR_LSB +: OSR_EXP_W]    = exp_q;
                reg_rdata[CB_IRQ]                     = irq_q;
            end
            ADDR_RESULT: reg_rdata = result_q;
            ADDR_ANALOG: reg_rdata = analog_q;
            default:     reg_rdata = '0;
        endcase
    end

    assign cont        = cont_q;
    assign start_pulse = start_q;
    assign def_pulse   = def_q;
    assign ncv         = ncv_q;
    assign osr_exp     = exp_q;
    assign irq         = irq_q;

    // R9: a result arrival always leaves the interrupt set
    a_r9_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> irq_q);

    // R9: reading the result with no new arrival clears the interrupt
    a_r9_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (result_rd && !done_pulse) |=> !irq_q);

    // R6: a defaults write restores the conversion length fields
    a_r6_def_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && reg_wdata[CB_DEF]) |=> (ncv_q == NCV_RST && exp_q == EXP_RST && analog_q == '0));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int OSR_BASE_LOG2 = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_pulse,
    input  logic                 def_pulse,
    input  logic                 cont,
    input  logic [NCV_W-1:0]     ncv_in,
    input  logic [OSR_EXP_W-1:0] osr_exp_in,
    input  logic                 smp_valid,
    input  logic [REG_W-1:0]     smp_data,
    output logic                 busy,
    output logic                 trig,
    output logic [REG_W-1:0]     result
);

    localparam int OSR_CNT_W = OSR_BASE_LOG2 + (1 << OSR_EXP_W) - 1;

    seq_state_e state_q, state_d;

    logic [OSR_CNT_W-1:0] osr_cnt_q, osr_lim_q, osr_lim_new;
    logic [NCV_W-1:0]     ncv_cnt_q, ncv_lim_q, ncv_lim_new;
    logic [OSR_CNT_W:0]   osr_full;
    logic                 osr_last;
    logic                 ncv_last;
    logic                 conv_last;
    logic                 load;
    logic                 trig_q;
    logic [REG_W-1:0]     result_q;

    assign osr_full    = (OSR_CNT_W+1)'(1) << (OSR_BASE_LOG2 + int'(osr_exp_in));
    assign osr_lim_new = osr_full[OSR_CNT_W-1:0] - OSR_CNT_W'(1);
    assign ncv_lim_new = (ncv_in == '0) ? '0 : ncv_in - NCV_W'(1);

    assign osr_last  = (osr_cnt_q == osr_lim_q);
    assign ncv_last  = (ncv_cnt_q == ncv_lim_q);
    assign conv_last = (state_q == SEQ_CONV) && smp_valid && osr_last && ncv_last;

    // next-state logic
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (def_pulse || start_pulse || cont) begin
                    state_d = SEQ_CONV;
                    load    = 1'b1;
                end
            end
            SEQ_CONV: begin
                if (def_pulse) begin
                    state_d = SEQ_CONV;
                    load    = 1'b1;
                end else if (conv_last) begin
                    if (cont) begin
                        state_d = SEQ_CONV;
                        load    = 1'b1;
                    end else begin
                        state_d = SEQ_IDLE;
                    end
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // sample and element counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osr_cnt_q <= '0;
            ncv_cnt_q <= '0;
            osr_lim_q <= '0;
            ncv_lim_q <= '0;
        end else if (load) begin
            osr_cnt_q <= '0;
            ncv_cnt_q <= '0;
            osr_lim_q <= osr_lim_new;
            ncv_lim_q <= ncv_lim_new;
        end else if (state_q == SEQ_CONV && smp_valid) begin
            if (osr_last) begin
                osr_cnt_q <= '0;
                ncv_cnt_q <= ncv_cnt_q + NCV_W'(1);
            end else begin
                osr_cnt_q <= osr_cnt_q + OSR_CNT_W'(1);
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q   <= 1'b0;
            result_q <= '0;
        end else begin
            trig_q <= conv_last && !def_pulse;
            if (conv_last && !def_pulse) begin
                result_q <= smp_data;
            end
        end
    end

    assign busy   = (state_q == SEQ_CONV);
    assign trig   = trig_q;
    assign result = result_q;

    // R3: the end-of-conversion trigger never lasts two cycles
    a_r3_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |=> !trig_q);

    // R3: a trigger only follows a cycle spent converting
    a_r3_trig_after_conv: assert property (@(posedge clk) disable iff (!rst_n)
        trig_q |-> $past(state_q == SEQ_CONV));

    // R5: a start in idle begins a conversion from count zero
    a_r5_start_begins: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && state_q == SEQ_IDLE) |=> (state_q == SEQ_CONV && osr_cnt_q == '0 && ncv_cnt_q == '0));

    // R5: a start during a conversion leaves the sample count running
    a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && state_q == SEQ_CONV && !osr_last && !def_pulse)
        |=> (state_q == SEQ_CONV && osr_cnt_q == $past(osr_cnt_q) + OSR_CNT_W'($past(smp_valid))));

    // R6: defaults always restart from count zero
    a_r6_def_restart: assert property (@(posedge clk) disable iff (!rst_n)
        def_pulse |=> (state_q == SEQ_CONV && osr_cnt_q == '0 && ncv_cnt_q == '0));

    // R7: the last sample with continuous clear ends in idle
    a_r7_cont_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_last && !cont && !def_pulse) |=> (state_q == SEQ_IDLE));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int OSR_BASE_LOG2 = 3,
    parameter int SYNC_STAGES   = 2,
    parameter int DEF_NCV       = 2,
    parameter int DEF_OSR_EXP   = 2
) (
    input  logic              cpu_clk,
    input  logic              cpu_rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq,
    input  logic              smp_clk,
    input  logic              smp_rst_n,
    input  logic              smp_valid,
    input  logic [REG_W-1:0]  smp_data,
    output logic              conv_trig
);

    logic                 cont_cpu;
    logic                 start_cpu;
    logic                 def_cpu;
    logic [NCV_W-1:0]     ncv_cpu;
    logic [OSR_EXP_W-1:0] exp_cpu;
    logic                 busy_cpu;
    logic                 done_cpu;

    logic                 cont_smp;
    logic                 start_smp;
    logic                 def_smp;
    logic                 busy_smp;
    logic                 trig_smp;
    logic [REG_W-1:0]     result_smp;

    adc_seq_regs #(
        .DEF_NCV     (DEF_NCV),
        .DEF_OSR_EXP (DEF_OSR_EXP)
    ) u_regs (
        .clk         (cpu_clk),
        .rst_n       (cpu_rst_n),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .busy_sync   (busy_cpu),
        .done_pulse  (done_cpu),
        .result_in   (result_smp),
        .cont        (cont_cpu),
        .start_pulse (start_cpu),
        .def_pulse   (def_cpu),
        .ncv         (ncv_cpu),
        .osr_exp     (exp_cpu),
        .irq         (irq)
    );

    adc_seq_tgl_sync #(.STAGES(SYNC_STAGES)) u_start_sync (
        .src_clk   (cpu_clk),
        .src_rst_n (cpu_rst_n),
        .src_pulse (start_cpu),
        .dst_clk   (smp_clk),
        .dst_rst_n (smp_rst_n),
        .dst_pulse (start_smp)
    );

    adc_seq_tgl_sync #(.STAGES(SYNC_STAGES)) u_def_sync (
        .src_clk   (cpu_clk),
        .src_rst_n (cpu_rst_n),
        .src_pulse (def_cpu),
        .dst_clk   (smp_clk),
        .dst_rst_n (smp_rst_n),
        .dst_pulse (def_smp)
    );

    adc_seq_bit_sync #(.STAGES(SYNC_STAGES)) u_cont_sync (
        .clk   (smp_clk),
        .rst_n (smp_rst_n),
        .d     (cont_cpu),
        .q     (cont_smp)
    );

    adc_seq_fsm #(.OSR_BASE_LOG2(OSR_BASE_LOG2)) u_fsm (
        .clk         (smp_clk),
        .rst_n       (smp_rst_n),
        .start_pulse (start_smp),
        .def_pulse   (def_smp),
        .cont        (cont_smp),
        .ncv_in      (ncv_cpu),
        .osr_exp_in  (exp_cpu),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data),
        .busy        (busy_smp),
        .trig        (trig_smp),
        .result      (result_smp)
    );

    adc_seq_bit_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
        .clk   (cpu_clk),
        .rst_n (cpu_rst_n),
        .d     (busy_smp),
        .q     (busy_cpu)
    );

    adc_seq_tgl_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .src_clk   (smp_clk),
        .src_rst_n (smp_rst_n),
        .src_pulse (trig_smp),
        .dst_clk   (cpu_clk),
        .dst_rst_n (cpu_rst_n),
        .dst_pulse (done_cpu)
    );

    assign conv_trig = trig_smp;

endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;

    logic        cpu_clk = 1'b0;
    logic        smp_clk = 1'b0;
    logic        cpu_rst_n = 1'b0;
    logic        smp_rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        irq;
    logic        smp_valid = 1'b1;
    logic [15:0] smp_data = 16'h0;
    logic        conv_trig;

    always #5  cpu_clk = ~cpu_clk;
    always #17 smp_clk = ~smp_clk;

    adc_seq_ctrl u_dut (
        .cpu_clk   (cpu_clk),
        .cpu_rst_n (cpu_rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .smp_clk   (smp_clk),
        .smp_rst_n (smp_rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .conv_trig (conv_trig)
    );

    // vector table: element count, exponent, valid divider, data
    localparam int VN [5] = '{2, 3, 0, 1, 4};
    localparam int VE [5] = '{0, 1, 1, 3, 0};
    localparam int VV [5] = '{1, 1, 1, 2, 2};
    localparam logic [15:0] VD [5] = '{16'h1234, 16'hBEEF, 16'h0F0F, 16'h8001, 16'h7E57};

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int smp_cyc = 0;
    int trig_cnt = 0;
    int last_trig_cyc = 0;
    int last_gap = 0;
    int valid_div = 1;
    bit vphase = 1'b0;

    always @(negedge smp_clk) begin
        smp_cyc++;
        vphase = ~vphase;
        smp_valid <= (valid_div == 1) ? 1'b1 : vphase;
        if (conv_trig) begin
            trig_cnt++;
            last_gap = smp_cyc - last_trig_cyc;
            last_trig_cyc = smp_cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] ctrl_word(input bit c, input bit s, input bit d, input int n, input int e);
        logic [15:0] w;
        w = 16'h0;
        w[0] = c;
        w[1] = s;
        w[2] = d;
        w[7:4] = 4'(n);
        w[9:8] = 2'(e);
        return w;
    endfunction

    task automatic cpu_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge cpu_clk);
        reg_addr = a;
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge cpu_clk);
        reg_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge cpu_clk);
        reg_addr = a;
        reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge cpu_clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle(output bit ok);
        logic [15:0] v;
        ok = 1'b0;
        for (int k = 0; k < 4000; k++) begin
            cpu_read(2'd0, v);
            if (!v[3]) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic wait_trigs(input int n);
        int t0;
        t0 = trig_cnt;
        for (int k = 0; k < 40000; k++) begin
            if (trig_cnt >= t0 + n) break;
            @(posedge cpu_clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge cpu_clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not complete)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        bit ok;
        int tc, t0, d, len;

        repeat (4) @(posedge smp_clk);
        @(negedge cpu_clk);
        cpu_rst_n = 1'b1;
        smp_rst_n = 1'b1;
        repeat (4) @(negedge cpu_clk);

        // R1: reset state
        cpu_read(2'd0, v);
        chk(v == 16'h0220, "R1 ctrl", v, 16'h0220);
        cpu_read(2'd1, v);
        chk(v == 16'h0, "R1 result", v, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        repeat (100) @(negedge smp_clk);
        chk(trig_cnt == 0, "R1 no spontaneous start", trig_cnt, 0);

        // R2 R3 R4 R7 R9: vector table in continuous mode
        for (int i = 0; i < 5; i++) begin
            smp_data = VD[i];
            valid_div = VV[i];
            len = ((VN[i] == 0) ? 1 : VN[i]) * (8 << VE[i]) * VV[i];
            t0 = trig_cnt;
            cpu_write(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, VN[i], VE[i]));
            wait_trigs(2);
            chk(trig_cnt >= t0 + 2, "R4 auto restart", trig_cnt - t0, 2);
            chk(last_gap == len, "R2 conversion length", last_gap, len);
            tc = trig_cnt;
            cpu_write(2'd0, ctrl_word(1'b0, 1'b0, 1'b0, VN[i], VE[i]));
            wait_idle(ok);
            repeat (10) @(negedge cpu_clk);
            chk(ok, "R7 stops", ok, 1);
            chk(trig_cnt == tc + 1, "R7 final conversion completes", trig_cnt - tc, 1);
            chk(irq == 1'b1, "R9 irq set", irq, 1);
            cpu_read(2'd1, v);
            chk(v == VD[i], "R3 result value", v, VD[i]);
            chk(irq == 1'b0, "R9 irq cleared by read", irq, 0);
            tc = trig_cnt;
            repeat (100) @(negedge smp_clk);
            chk(trig_cnt == tc, "R7 stays stopped", trig_cnt - tc, 0);
        end

        // R10: analog settings storage
        cpu_write(2'd2, 16'hABCD);
        cpu_read(2'd2, v);
        chk(v == 16'hABCD, "R10 analog readback", v, 16'hABCD);

        // R5 R8: on-request conversion, start during conversion ignored
        valid_div = 1;
        smp_data = 16'hC0DE;
        cpu_read(2'd0, v);
        chk(v[3] == 1'b0, "R8 busy low when idle", v[3], 0);
        tc = trig_cnt;
        t0 = smp_cyc;
        cpu_write(2'd0, ctrl_word(1'b0, 1'b1, 1'b0, 4, 3));
        ok = 1'b0;
        for (int k = 0; k < 40; k++) begin
            cpu_read(2'd0, v);
            if (v[3]) begin
                ok = 1'b1;
                break;
            end
        end
        chk(ok, "R8 busy rises after start", ok, 1);
        repeat (50) @(negedge smp_clk);
        cpu_write(2'd0, ctrl_word(1'b0, 1'b1, 1'b0, 4, 3));
        wait_idle(ok);
        repeat (10) @(negedge cpu_clk);
        chk(trig_cnt == tc + 1, "R5 one conversion per start", trig_cnt - tc, 1);
        d = last_trig_cyc - t0;
        chk(d >= 256 && d <= 262, "R5 length unaffected by second start", d, 259);
        cpu_read(2'd1, v);
        chk(v == 16'hC0DE, "R3 on-request result", v, 16'hC0DE);
        tc = trig_cnt;
        repeat (100) @(negedge smp_clk);
        chk(trig_cnt == tc, "R5 no automatic restart", trig_cnt - tc, 0);

        // R6: defaults abort a long conversion
        smp_data = 16'h5A5A;
        cpu_write(2'd0, ctrl_word(1'b0, 1'b1, 1'b0, 15, 3));
        repeat (100) @(negedge smp_clk);
        tc = trig_cnt;
        t0 = smp_cyc;
        cpu_write(2'd0, ctrl_word(1'b0, 1'b0, 1'b1, 7, 1));
        wait_idle(ok);
        repeat (10) @(negedge cpu_clk);
        chk(trig_cnt == tc + 1, "R6 single restarted conversion", trig_cnt - tc, 1);
        d = last_trig_cyc - t0;
        chk(d >= 64 && d <= 70, "R6 restart length 64", d, 67);
        cpu_read(2'd0, v);
        chk((v & 16'h03F1) == 16'h0220, "R6 fields restored", v & 16'h03F1, 16'h0220);
        cpu_read(2'd2, v);
        chk(v == 16'h0, "R6 R10 analog cleared", v, 0);
        cpu_read(2'd1, v);
        chk(v == 16'h5A5A, "R6 result after restart", v, 16'h5A5A);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule